// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core goes to sleep and when it comes back. It watches the wait-for-event and wait-for-interrupt instruction strobes, the send-event strobe, exception entry and return strobes, the pending, enable and priority state of every interrupt line, the current execution priority, a global interrupt mask, an external event line and a debug request. It keeps the core's one-bit event register and reports whether the core is asleep, whether that sleep is the deep variant, when it wakes, and whether handler entry must be held back.

The two sleep instructions follow different wake rules. A wait-for-event sleep ends on any event, on a serviceable unmasked interrupt or on debug, and it consumes the stored event. If an event is already stored, it does not sleep at all. A wait-for-interrupt sleep ends only on an interrupt that outranks the current priority, or on debug. If that interrupt is blocked by the global mask, the core still wakes, but a hold flag tells the exception logic to wait until the mask is lifted. A third way into sleep is sleep-on-exit: an exception return to thread mode puts the core back to sleep when that control bit is set.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, `sleeping_o`, `deep_o`, `wake_o`, `hold_irq_o` and `event_o` are all 0.
- R2: The event register (`event_o`) is one bit wide. It becomes 1 on the clock edge after any of these: a `sev_i` strobe, `ext_evt_i`, `exc_entry_i`, `exc_ret_i`, or a serviceable interrupt while `global_mask_i` is 0. Several sources together still store one event. A stored event stays until a wait-for-event consumes it.
- R3: When `ctl_pend_evt_i` is 1, a bit of `irq_pend_i` going from 0 to 1 counts as an event, even if its enable bit is 0. A pending bit that stays at 1 never counts as an event. When `ctl_pend_evt_i` is 0, new pending bits do not count as events.
- R4: A `wfe_i` strobe while awake, with the event register at 1 or an event source active in the same cycle, clears the event register and leaves the core awake with no wake pulse.
- R5: A `wfe_i` strobe while awake with no event stored or arriving makes `sleeping_o` 1 on the next edge. Any event source, a serviceable unmasked interrupt or `dbg_req_i` ends that sleep, and the event register is 0 afterwards.
- R6: A wait-for-interrupt sleep, entered by a `wfi_i` strobe, ends only on a serviceable interrupt or on `dbg_req_i`. Send-event, the external event and new-pending events do not end it, but they are still stored in the event register.
- R7: When a serviceable interrupt ends a wait-for-interrupt sleep while `global_mask_i` is 1, `hold_irq_o` becomes 1 together with the wake. It stays 1 until the cycle after `global_mask_i` is seen at 0.
- R8: An interrupt is serviceable when its pending and enable bits are both 1 and its 2-bit priority field (bits 2i+1:2i of `irq_prio_i`) is numerically smaller than the 3-bit `cur_prio_i`. A lower number means more urgent. Values 4 to 7 of `cur_prio_i` stand for thread mode, which every interrupt outranks.
- R9: `deep_o` takes the value of `ctl_deep_i` sampled at sleep entry. It holds that value for the whole sleep, whatever `ctl_deep_i` does later, and it is 0 whenever `sleeping_o` is 0.
- R10: When `ctl_sleep_ret_i` is 1, an `exc_ret_i` strobe with `ret_thread_i` at 1 starts a sleep that follows the wait-for-interrupt wake rules. The same strobe with `ret_thread_i` at 0 does not start a sleep.
- R11: `wake_o` is a pulse exactly one cycle long. It appears on the edge after the wake condition, on the same edge where `sleeping_o` drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfe_i | input | 1 | Wait-for-event instruction strobe |
| wfi_i | input | 1 | Wait-for-interrupt instruction strobe |
| sev_i | input | 1 | Send-event instruction strobe |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_ret_i | input | 1 | Exception return strobe |
| ret_thread_i | input | 1 | The exception return goes back to thread mode |
| ctl_deep_i | input | 1 | Deep-sleep select for the next sleep entry |
| ctl_pend_evt_i | input | 1 | Newly pending interrupts count as events |
| ctl_sleep_ret_i | input | 1 | Sleep again on return to thread mode |
| irq_pend_i | input | N_IRQ | Per-interrupt pending bits |
| irq_en_i | input | N_IRQ | Per-interrupt enable bits |
| irq_prio_i | input | N_IRQ*PRIO_W | Packed priorities, lower is more urgent |
| cur_prio_i | input | PRIO_W+1 | Current execution priority; 4..7 means thread mode |
| global_mask_i | input | 1 | Global interrupt mask |
| ext_evt_i | input | 1 | External event input |
| dbg_req_i | input | 1 | Debug request |
| sleeping_o | output | 1 | Core is asleep |
| deep_o | output | 1 | Current sleep is the deep variant |
| wake_o | output | 1 | One-cycle wake pulse |
| hold_irq_o | output | 1 | Hold back handler entry until the mask is cleared |
| event_o | output | 1 | Event register |

## Verification
The bench targets a wait-for-event that meets a stored event. A design that slept there would hang a polling loop. It checks that a wait-for-interrupt sleep ignores send-event and external events, since a design that woke on them would break interrupt-driven code. It raises an interrupt that is pending but does not outrank the current level, then a masked interrupt during wait-for-interrupt. Getting either wrong would wake the core too early or run a handler while the mask is still set. It also holds a pending line high under the new-pending setting, to catch a design that wakes on a level instead of an edge. Finally, it changes the deep-sleep bit mid-sleep and uses returns to both thread and handler mode, so a design that sampled the deep bit late or slept on every return would show up against the cycle model.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
package slp_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_WFE   = 2'd1,
        ST_WFI   = 2'd2
    } slp_state_e;

    typedef struct packed {
        slp_state_e state;
        logic       deep;
        logic       wake;
        logic       hold;
    } fsm_regs_t;

endpackage

// File: rtl/irq_scan.sv
`timescale 1ns/1ps
module irq_scan #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IRQ-1:0]         pend_i,
    input  logic [N_IRQ-1:0]         en_i,
    input  logic [N_IRQ*PRIO_W-1:0]  prio_i,
    input  logic [PRIO_W:0]          cur_prio_i,
    output logic                     svc_o,
    output logic                     newpend_o
);
    logic [N_IRQ-1:0] outrank;
    logic [N_IRQ-1:0] pend_d, pend_q;

    // one comparator per line; thread levels sit above every field value
    for (genvar g = 0; g < N_IRQ; g++) begin : g_rank
        assign outrank[g] = {1'b0, prio_i[g*PRIO_W +: PRIO_W]} < cur_prio_i;
    end

    always_comb begin
        pend_d    = pend_i;
        newpend_o = |(pend_i & ~pend_q);
        svc_o     = |(pend_i & en_i & outrank);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R8: in thread mode any enabled pending line is serviceable
    a_r8_thread_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_prio_i[PRIO_W] && |(pend_i & en_i)) |-> svc_o);

    // R3: a line held high is not new on the following cycle
    a_r3_level_not_new: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == pend_q) |-> !newpend_o);

endmodule

// File: rtl/evt_latch.sv
`timescale 1ns/1ps
module evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic consume_i,
    output logic evt_o
);
    logic evt_d, evt_q;

    always_comb begin
        if (consume_i) evt_d = 1'b0;
        else           evt_d = evt_q | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end

    assign evt_o = evt_q;

    // R2: consuming always leaves the register empty
    a_r2_consume_clears: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> !evt_o);

    // R2: an unconsumed source is remembered
    a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !consume_i) |=> evt_o);

endmodule

// File: rtl/sleep_fsm.sv
`timescale 1ns/1ps
module sleep_fsm
    import slp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfe_i,
    input  logic wfi_i,
    input  logic ret_sleep_i,
    input  logic deep_ctl_i,
    input  logic evt_q_i,
    input  logic evt_src_i,
    input  logic svc_i,
    input  logic mask_i,
    input  logic dbg_i,
    output logic sleeping_o,
    output logic deep_o,
    output logic wake_o,
    output logic hold_o,
    output logic consume_o
);
    fsm_regs_t cur_q, nxt_d;
    logic      evt_now;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.wake = 1'b0;
        nxt_d.hold = cur_q.hold & mask_i;
        consume_o  = 1'b0;
        evt_now    = evt_q_i | evt_src_i;
        case (cur_q.state)
            ST_AWAKE: begin
                if (wfe_i) begin
                    if (evt_now) begin
                        consume_o = 1'b1;
                    end else begin
                        nxt_d.state = ST_WFE;
                        nxt_d.deep  = deep_ctl_i;
                    end
                end else if (wfi_i || ret_sleep_i) begin
                    nxt_d.state = ST_WFI;
                    nxt_d.deep  = deep_ctl_i;
                end
            end
            ST_WFE: begin
                if (evt_src_i || dbg_i) begin
                    nxt_d.state = ST_AWAKE;
                    nxt_d.deep  = 1'b0;
                    nxt_d.wake  = 1'b1;
                    consume_o   = 1'b1;
                end
            end
            ST_WFI: begin
                if (svc_i || dbg_i) begin
                    nxt_d.state = ST_AWAKE;
                    nxt_d.deep  = 1'b0;
                    nxt_d.wake  = 1'b1;
                    if (svc_i && mask_i) nxt_d.hold = 1'b1;
                end
            end
            default: begin
                nxt_d.state = ST_AWAKE;
                nxt_d.deep  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_AWAKE;
            cur_q.deep  <= 1'b0;
            cur_q.wake  <= 1'b0;
            cur_q.hold  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sleeping_o = (cur_q.state != ST_AWAKE);
    assign deep_o     = cur_q.deep;
    assign wake_o     = cur_q.wake;
    assign hold_o     = cur_q.hold;

    // R11: the wake pulse never lasts two cycles
    a_r11_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R11: a wake pulse follows a sleeping cycle and coincides with being awake
    a_r11_wake_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(sleeping_o) && !sleeping_o));

    // R9: deep status only while asleep
    a_r9_deep_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        deep_o |-> sleeping_o);

    // R4: an available event makes the wait complete without sleeping
    a_r4_wfe_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping_o && wfe_i && (evt_q_i || evt_src_i)) |=> (!sleeping_o && !evt_q_i));

    // R6: wait-for-interrupt sleep persists without an interrupt or debug
    a_r6_wfi_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_WFI && !svc_i && !dbg_i) |=> sleeping_o);

    // R7: the hold flag falls once the mask is gone
    a_r7_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && !mask_i) |=> !hold_o);

endmodule

// File: rtl/sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sleep_wake_ctrl #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wfe_i,
    input  logic                    wfi_i,
    input  logic                    sev_i,
    input  logic                    exc_entry_i,
    input  logic                    exc_ret_i,
    input  logic                    ret_thread_i,
    input  logic                    ctl_deep_i,
    input  logic                    ctl_pend_evt_i,
    input  logic                    ctl_sleep_ret_i,
    input  logic [N_IRQ-1:0]        irq_pend_i,
    input  logic [N_IRQ-1:0]        irq_en_i,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic [PRIO_W:0]         cur_prio_i,
    input  logic                    global_mask_i,
    input  logic                    ext_evt_i,
    input  logic                    dbg_req_i,
    output logic                    sleeping_o,
    output logic                    deep_o,
    output logic                    wake_o,
    output logic                    hold_irq_o,
    output logic                    event_o
);
    logic svc, newpend, evt_src, ret_sleep, consume;

    irq_scan #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (irq_pend_i),
        .en_i       (irq_en_i),
        .prio_i     (irq_prio_i),
        .cur_prio_i (cur_prio_i),
        .svc_o      (svc),
        .newpend_o  (newpend)
    );

    assign evt_src = sev_i | ext_evt_i | exc_entry_i | exc_ret_i
                   | (svc & ~global_mask_i)
                   | (ctl_pend_evt_i & newpend);

    assign ret_sleep = exc_ret_i & ret_thread_i & ctl_sleep_ret_i;

    evt_latch u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_src),
        .consume_i (consume),
        .evt_o     (event_o)
    );

    sleep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wfe_i       (wfe_i),
        .wfi_i       (wfi_i),
        .ret_sleep_i (ret_sleep),
        .deep_ctl_i  (ctl_deep_i),
        .evt_q_i     (event_o),
        .evt_src_i   (evt_src),
        .svc_i       (svc),
        .mask_i      (global_mask_i),
        .dbg_i       (dbg_req_i),
        .sleeping_o  (sleeping_o),
        .deep_o      (deep_o),
        .wake_o      (wake_o),
        .hold_o      (hold_irq_o),
        .consume_o   (consume)
    );

    // R10: a return to thread with the control bit set enters sleep
    a_r10_ret_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping_o && !wfe_i && exc_ret_i && ret_thread_i && ctl_sleep_ret_i) |=> sleeping_o);

    // R2: an external event is never lost while awake without a wait
    a_r2_ext_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleeping_o && !wfe_i && ext_evt_i) |=> event_o);

endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfe = 0, wfi = 0, sev = 0, entry = 0, ret = 0, ret_thr = 0;
    logic deep = 0, evp = 0, exitc = 0, pm = 0, ext = 0, dbg = 0;
    logic [7:0]  pend = '0, en = '0;
    logic [15:0] prio = '0;
    logic [2:0]  cur = 3'd4;
    logic sleeping, deep_o, wake, hold, evt;

    int checks = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sleep_wake_ctrl #(.N_IRQ(8), .PRIO_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wfe_i(wfe), .wfi_i(wfi), .sev_i(sev),
        .exc_entry_i(entry), .exc_ret_i(ret), .ret_thread_i(ret_thr),
        .ctl_deep_i(deep), .ctl_pend_evt_i(evp), .ctl_sleep_ret_i(exitc),
        .irq_pend_i(pend), .irq_en_i(en), .irq_prio_i(prio), .cur_prio_i(cur),
        .global_mask_i(pm), .ext_evt_i(ext), .dbg_req_i(dbg),
        .sleeping_o(sleeping), .deep_o(deep_o), .wake_o(wake),
        .hold_irq_o(hold), .event_o(evt)
    );

    // behavioural reference: mode 0 awake, 1 event wait, 2 interrupt wait
    int   m_mode;
    bit   m_deep, m_wake, m_hold, m_evt;
    logic [7:0] m_prev;

    always @(posedge clk) begin : ref_model
        bit svc, src, take, go_awake;
        int pr;
        if (!rst_n) begin
            m_mode = 0; m_deep = 0; m_wake = 0; m_hold = 0; m_evt = 0; m_prev = '0;
        end else begin
            svc = 0;
            for (int i = 0; i < 8; i++) begin
                pr = prio[2*i +: 2];
                if (pend[i] && en[i] && pr < int'(cur)) svc = 1;
            end
            src = sev || ext || entry || ret || (svc && !pm)
                  || (evp && ((pend & ~m_prev) != 0));
            take = 0; go_awake = 0;
            m_hold = m_hold && pm;
            m_wake = 0;
            if (m_mode == 0) begin
                if (wfe) begin
                    if (m_evt || src) take = 1;
                    else begin m_mode = 1; m_deep = deep; end
                end else if (wfi || (ret && ret_thr && exitc)) begin
                    m_mode = 2; m_deep = deep;
                end
            end else if (m_mode == 1) begin
                if (src || dbg) begin go_awake = 1; take = 1; end
            end else begin
                if (svc || dbg) begin
                    go_awake = 1;
                    if (svc && pm) m_hold = 1;
                end
            end
            if (go_awake) begin m_mode = 0; m_deep = 0; m_wake = 1; end
            m_evt = take ? 1'b0 : (m_evt || src);
            m_prev = pend;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 sleeping", sleeping, m_mode != 0);
            chk("R9 deep",     deep_o,   m_deep);
            chk("R11 wake",    wake,     m_wake);
            chk("R7 hold",     hold,     m_hold);
            chk("R2 event",    evt,      m_evt);
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : stim
        prio = {2'd3, 2'd1, 2'd3, 2'd0, 2'd3, 2'd1, 2'd2, 2'd3};
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 sleeping", sleeping, 0); chk("R1 event", evt, 0);
        chk("R1 wake", wake, 0); chk("R1 hold", hold, 0); chk("R1 deep", deep_o, 0);

        // R2: send-event, then two sources together, one stored bit
        sev = 1; step(); sev = 0;
        chk("R2 sev stored", evt, 1);
        ext = 1; entry = 1; step(); ext = 0; entry = 0;
        chk("R2 collapse", evt, 1);
        // R4: wait-for-event with stored event completes at once
        wfe = 1; step(); wfe = 0;
        chk("R4 no sleep", sleeping, 0); chk("R4 cleared", evt, 0); chk("R4 no wake", wake, 0);

        // R5 and R9: deep event wait, woken by external event
        deep = 1; wfe = 1; step(); wfe = 0;
        chk("R5 asleep", sleeping, 1); chk("R9 deep at entry", deep_o, 1);
        deep = 0; step(3);
        chk("R9 deep held", deep_o, 1);
        ext = 1; step(); ext = 0;
        chk("R11 wake pulse", wake, 1); chk("R5 awake", sleeping, 0); chk("R5 event left 0", evt, 0);
        step();
        chk("R11 pulse ends", wake, 0);

        // R6: interrupt wait ignores send-event but stores it
        wfi = 1; step(); wfi = 0;
        sev = 1; step(); sev = 0;
        chk("R6 sev no wake", sleeping, 1); chk("R6 sev stored", evt, 1);
        // R8: pending line at priority 1 does not outrank current level 1
        cur = 3'd1; en[2] = 1; pend[2] = 1; step(2);
        chk("R8 equal prio no wake", sleeping, 1);
        cur = 3'd4; step();
        chk("R8 thread outranked wake", sleeping, 0);
        pend[2] = 0; en[2] = 0;
        wfe = 1; step(); wfe = 0;           // consume stored event
        chk("R4 consumed", evt, 0);

        // R7: masked interrupt wakes interrupt wait and holds handler
        pm = 1; wfi = 1; step(); wfi = 0;
        en[3] = 1; pend[3] = 1; step();
        chk("R7 masked wake", sleeping, 0); chk("R7 hold set", hold, 1);
        pend[3] = 0; en[3] = 0; step(2);
        chk("R7 hold kept", hold, 1);
        pm = 0; step();
        chk("R7 hold released", hold, 0);

        // R3: new pending disabled line wakes event wait; level does not
        evp = 1; wfe = 1; step(); wfe = 0;
        chk("R3 asleep", sleeping, 1);
        pend[5] = 1; step();
        chk("R3 edge wakes", sleeping, 0); chk("R3 event left 0", evt, 0);
        wfe = 1; step(); wfe = 0; step(3);
        chk("R3 level no wake", sleeping, 1);
        dbg = 1; step(); dbg = 0;
        chk("R5 debug wakes", sleeping, 0);
        pend[5] = 0; step(); pend[5] = 1; step();
        chk("R3 awake edge stored", evt, 1);
        wfe = 1; step(); wfe = 0;
        evp = 0; pend[5] = 0; step(); pend[5] = 1; step();
        chk("R3 disabled no event", evt, 0);
        pend[5] = 0;

        // R10: sleep-on-exit to thread, interrupt-wait rules apply
        exitc = 1; ret = 1; ret_thr = 1; step(); ret = 0; ret_thr = 0;
        chk("R10 sleeps on return", sleeping, 1); chk("R10 return is event", evt, 1);
        ext = 1; step(); ext = 0;
        chk("R10 event no wake", sleeping, 1);
        dbg = 1; step(); dbg = 0;
        chk("R10 debug wakes", sleeping, 0);
        ret = 1; ret_thr = 0; step(); ret = 0;
        chk("R10 handler return no sleep", sleeping, 0);
        exitc = 0;

        // mixed stimulus, checked against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            wfe = ($urandom % 12) == 0;  wfi = ($urandom % 14) == 0;
            sev = ($urandom % 20) == 0;  ext = ($urandom % 25) == 0;
            entry = ($urandom % 40) == 0; ret = ($urandom % 30) == 0;
            ret_thr = $urandom; deep = $urandom; evp = $urandom;
            exitc = $urandom; dbg = ($urandom % 50) == 0;
            if (($urandom % 8) == 0) pm = $urandom;
            if (($urandom % 6) == 0) pend = pend ^ (8'd1 << ($urandom % 8));
            if (($urandom % 10) == 0) en = $urandom;
            if (($urandom % 15) == 0) cur = $urandom;
            if (($urandom % 40) == 0) prio = $urandom;
        end
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule